// File: doc/BRIEF.md
# Quadrant-Aware DRAM Command Spacing Checker

This block watches the row and column commands a memory controller issues to a sixteen-bank DRAM core. The core groups its banks into four quadrants. Each quadrant has its own row circuitry and its own column circuitry. The checker judges every command as it arrives and reports one cycle later whether the command was legal. When it was not, the block also reports why.

Row spacing is tracked per quadrant. After a row command to any bank of a quadrant, the rest of that quadrant is barred from row activity for the row-cycle time. The other quadrants stay free during that time. Column spacing is tracked per bank, so different banks proceed in parallel, even banks in the same quadrant.

The controller supplies a free-running cycle count with each clock. The block measures elapsed time as the difference between that count and the stored start time of each timer. A command that breaks a rule is not recorded, so only accepted commands restart a timer. All timing values are parameters given in clock cycles. The default column-cycle time is 16 cycles and the default row-cycle time is twice that.

Top module: `qtc_cmd_checker`

## Requirements
- R1: After reset, `res_vld` is 0 and every timer is expired: the first row command to any bank is accepted.
- R2: Each cycle with `cmd_vld`=1 produces exactly one result with `res_vld`=1 on the next cycle. A cycle with `cmd_vld`=0 produces `res_vld`=0 on the next cycle.
- R3: The quadrant of a bank is `cmd_bank[1:0]`. A row command (`cmd_is_col`=0) is rejected with code 1 when the last accepted row command to the same quadrant started fewer than T_RR cycles earlier, as measured on `now_cyc`.
- R4: A row command is accepted with code 0 while other quadrants are inside their row window.
- R5: A row command issued exactly T_RR cycles after the last accepted row command in its quadrant is accepted.
- R6: A column command (`cmd_is_col`=1) is rejected with code 2 when the last accepted column command to the same bank started fewer than T_CC cycles earlier. At exactly T_CC cycles it is accepted.
- R7: A column command to a different bank is accepted during another bank's column window, including a bank in the same quadrant.
- R8: A column command to a bank that has had no accepted row command since reset is rejected with code 3. This code takes priority over code 2.
- R9: A rejected command restarts no timer and opens no row.
- R10: `res_ok` is 1 exactly when `res_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| now_cyc | input | TS_W | Free-running cycle count, advancing by one per clock |
| cmd_vld | input | 1 | A command is presented this cycle |
| cmd_is_col | input | 1 | 1 = column command, 0 = row command |
| cmd_bank | input | log2(NUM_BANKS) | Target bank; low two bits select the quadrant |
| res_vld | output | 1 | Verdict for the previous cycle's command |
| res_ok | output | 1 | 1 = command legal |
| res_code | output | 2 | 0 ok, 1 row spacing, 2 column spacing, 3 no open row |

## Verification
The bench sends four kinds of command patterns. Bursts of row commands across all four quadrants show whether row spacing is kept per quadrant or for the whole device. Row commands to the same quadrant one cycle before and exactly at the window boundary expose off-by-one errors in the comparison. Column commands alternate between the same bank, a sibling bank in the same quadrant, and banks in other quadrants, which separates per-bank column spacing from per-quadrant column spacing. Rejected commands are followed by retries at the boundary and by column accesses to banks whose row was refused, which shows whether an illegal command wrongly restarts a timer or opens a row.

// File: rtl/qtc_pkg.sv
package qtc_pkg;
  typedef enum logic [1:0] {
    CHK_OK          = 2'd0,
    CHK_ROW_SPACING = 2'd1,
    CHK_COL_SPACING = 2'd2,
    CHK_NO_ROW      = 2'd3
  } chk_code_e;
endpackage

// File: rtl/qtc_span_timer.sv
module qtc_span_timer #(
  parameter int TS_W  = 16,
  parameter int LIMIT = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TS_W-1:0] now,
  input  logic            start_en,
  output logic            busy
);
  localparam logic [TS_W-1:0] LIM = TS_W'(LIMIT);

  logic            live_q, live_d;
  logic [TS_W-1:0] t0_q, t0_d;
  logic [TS_W-1:0] elapsed;
  logic            in_window;

  assign elapsed   = now - t0_q;
  assign in_window = elapsed < LIM;
  assign busy      = live_q && in_window;

  always_comb begin
    live_d = live_q;
    t0_d   = t0_q;
    if (start_en) begin
      live_d = 1'b1;
      t0_d   = now;
    end else if (live_q && !in_window) begin
      live_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= 1'b0;
      t0_q   <= '0;
    end else begin
      live_q <= live_d;
      if (start_en) t0_q <= t0_d;
    end
  end

  // R9: a timer is only restarted once its window has closed
  a_r9_start_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_en |-> !busy);
  // R6: a freshly started timer reports busy on the next cycle
  a_r6_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start_en |=> busy);
endmodule

// File: rtl/qtc_row_quads.sv
module qtc_row_quads #(
  parameter int TS_W      = 16,
  parameter int NUM_QUADS = 4,
  parameter int T_RR      = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TS_W-1:0]      now,
  input  logic [NUM_QUADS-1:0] start_en,
  output logic [NUM_QUADS-1:0] quad_busy
);
  for (genvar g = 0; g < NUM_QUADS; g++) begin : g_quad
    qtc_span_timer #(.TS_W(TS_W), .LIMIT(T_RR)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .now      (now),
      .start_en (start_en[g]),
      .busy     (quad_busy[g])
    );
  end

  // R3: at most one quadrant row timer restarts per cycle
  a_r3_one_row_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(start_en));
endmodule

// File: rtl/qtc_bank_cols.sv
module qtc_bank_cols #(
  parameter int TS_W      = 16,
  parameter int NUM_BANKS = 16,
  parameter int T_CC      = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TS_W-1:0]      now,
  input  logic [NUM_BANKS-1:0] col_start_en,
  input  logic [NUM_BANKS-1:0] open_set,
  output logic [NUM_BANKS-1:0] bank_busy,
  output logic [NUM_BANKS-1:0] bank_open
);
  logic [NUM_BANKS-1:0] open_q, open_d;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    qtc_span_timer #(.TS_W(TS_W), .LIMIT(T_CC)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .now      (now),
      .start_en (col_start_en[g]),
      .busy     (bank_busy[g])
    );
  end

  always_comb begin
    open_d = open_q | open_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) open_q <= '0;
    else        open_q <= open_d;
  end

  assign bank_open = open_q;

  // R8: a column timer only starts on a bank whose row is open
  a_r8_col_needs_open: assert property (@(posedge clk) disable iff (!rst_n)
    (col_start_en & ~open_q) == '0);
  // R7: at most one bank column timer restarts per cycle
  a_r7_one_col_start: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(col_start_en));
  // R9: no row opens in a cycle with a column start
  a_r9_exclusive_starts: assert property (@(posedge clk) disable iff (!rst_n)
    !((|open_set) && (|col_start_en)));
endmodule

// File: rtl/qtc_cmd_checker.sv
module qtc_cmd_checker #(
  parameter int TS_W      = 16,
  parameter int NUM_BANKS = 16,
  parameter int NUM_QUADS = 4,
  parameter int T_CC      = 16,
  parameter int T_RR      = 2 * T_CC
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [TS_W-1:0]              now_cyc,
  input  logic                         cmd_vld,
  input  logic                         cmd_is_col,
  input  logic [$clog2(NUM_BANKS)-1:0] cmd_bank,
  output logic                         res_vld,
  output logic                         res_ok,
  output logic [1:0]                   res_code
);
  import qtc_pkg::*;

  localparam int QB = $clog2(NUM_QUADS);
  localparam int BB = $clog2(NUM_BANKS);

  // reset synchroniser: asserts at once, releases on the clock
  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [QB-1:0]        quad_idx;
  logic [NUM_QUADS-1:0] quad_busy, row_start_en;
  logic [NUM_BANKS-1:0] bank_busy, bank_open, col_start_en, open_set;
  chk_code_e            code_d, code_q;
  logic                 accept;
  logic                 vld_d, vld_q;

  assign quad_idx = cmd_bank[QB-1:0];

  qtc_row_quads #(.TS_W(TS_W), .NUM_QUADS(NUM_QUADS), .T_RR(T_RR)) u_rows (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .now       (now_cyc),
    .start_en  (row_start_en),
    .quad_busy (quad_busy)
  );

  qtc_bank_cols #(.TS_W(TS_W), .NUM_BANKS(NUM_BANKS), .T_CC(T_CC)) u_cols (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .now          (now_cyc),
    .col_start_en (col_start_en),
    .open_set     (open_set),
    .bank_busy    (bank_busy),
    .bank_open    (bank_open)
  );

  // verdict: no-open-row outranks column spacing
  always_comb begin
    code_d = CHK_OK;
    if (cmd_vld) begin
      if (!cmd_is_col) begin
        if (quad_busy[quad_idx]) code_d = CHK_ROW_SPACING;
      end else if (!bank_open[cmd_bank]) begin
        code_d = CHK_NO_ROW;
      end else if (bank_busy[cmd_bank]) begin
        code_d = CHK_COL_SPACING;
      end
    end
    accept = cmd_vld && (code_d == CHK_OK);
    vld_d  = cmd_vld;
  end

  always_comb begin
    row_start_en = '0;
    open_set     = '0;
    col_start_en = '0;
    if (accept && !cmd_is_col) begin
      row_start_en[quad_idx] = 1'b1;
      open_set[cmd_bank]     = 1'b1;
    end
    if (accept && cmd_is_col) col_start_en[cmd_bank] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      vld_q  <= 1'b0;
      code_q <= CHK_OK;
    end else begin
      vld_q <= vld_d;
      if (vld_d) code_q <= code_d;
    end
  end

  assign res_vld  = vld_q;
  assign res_code = code_q;
  assign res_ok   = vld_q && (code_q == CHK_OK);

  // R2: one verdict per command, on the next cycle
  a_r2_result_follows_cmd: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cmd_vld |=> res_vld);
  a_r2_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cmd_vld |=> !res_vld);
  // R3: a row command into a busy quadrant is refused for row spacing
  a_r3_busy_quad_rejects: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_vld && !cmd_is_col && quad_busy[quad_idx]) |=> (res_code == 2'd1));
  // R10: ok flag agrees with the code
  a_r10_ok_matches_code: assert property (@(posedge clk) disable iff (!rst_sync_n)
    res_vld |-> (res_ok == (res_code == 2'd0)));
  // R9: a refused command starts nothing
  a_r9_reject_no_start: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cmd_vld && code_d != CHK_OK) |-> (row_start_en == '0 && col_start_en == '0));
endmodule

// File: tb/qtc_cmd_checker_tb_top.sv
module qtc_cmd_checker_tb_top;
  localparam int TS_W = 16;
  localparam int TCC  = 16;
  localparam int TRR  = 2 * TCC;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [TS_W-1:0] now_cyc = '0;
  logic            cmd_vld = 1'b0;
  logic            cmd_is_col = 1'b0;
  logic [3:0]      cmd_bank = '0;
  logic            res_vld, res_ok;
  logic [1:0]      res_code;

  int checks = 0;
  int fails  = 0;
  int    exp_q[$];
  string req_q[$];
  bit    done = 1'b0;

  always #5 clk = ~clk;

  qtc_cmd_checker #(.TS_W(TS_W), .T_CC(TCC), .T_RR(TRR)) dut_i (
    .clk(clk), .rst_n(rst_n), .now_cyc(now_cyc), .cmd_vld(cmd_vld),
    .cmd_is_col(cmd_is_col), .cmd_bank(cmd_bank),
    .res_vld(res_vld), .res_ok(res_ok), .res_code(res_code)
  );

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      now_cyc = now_cyc + 1'b1;
      cmd_vld = 1'b0;
    end
  endtask

  task automatic issue(input bit col, input int bank, input int exp, input string req);
    @(negedge clk);
    now_cyc    = now_cyc + 1'b1;
    cmd_vld    = 1'b1;
    cmd_is_col = col;
    cmd_bank   = 4'(bank);
    exp_q.push_back(exp);
    req_q.push_back(req);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (res_vld) begin
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R2: result with no command pending, actual code %0d expected none", res_code);
        end else begin
          int    e;
          string r;
          e = exp_q.pop_front();
          r = req_q.pop_front();
          if (res_code != 2'(e) || res_ok != (e == 0)) begin
            fails++;
            $display("FAIL %s: actual code %0d ok %0d, expected code %0d ok %0d",
                     r, res_code, res_ok, e, (e == 0));
          end
        end
      end
    end
  end

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
      end
    join_none

    idle(3);
    rst_n = 1'b1;
    idle(4);
    checks++;
    if (res_vld !== 1'b0) begin
      fails++;
      $display("FAIL R1: res_vld after reset actual %0b expected 0", res_vld);
    end

    // R8: column to bank 5 before any row
    issue(1, 5, 3, "R8");
    // R1: first row after reset, bank 0 (quadrant 0) at time A
    issue(0, 0, 0, "R1");
    issue(0, 4, 1, "R3");          // A+1, quadrant 0 busy
    issue(0, 1, 0, "R4");          // A+2, quadrant 1
    issue(0, 2, 0, "R4");          // A+3, quadrant 2
    issue(0, 3, 0, "R4");          // A+4, quadrant 3
    idle(26);
    issue(0, 8, 1, "R3");          // A+31, one short of the window
    issue(0, 8, 0, "R5");          // A+32, exactly T_RR; R9 rejection did not restart
    issue(1, 0, 0, "R6");          // A+33 column bank 0
    issue(1, 4, 3, "R9");          // bank 4 row was refused, so no open row
    issue(1, 8, 0, "R7");          // A+35 same quadrant, other bank
    issue(1, 1, 0, "R7");          // A+36 other quadrant
    issue(1, 0, 2, "R6");          // A+37 bank 0 still in window
    idle(10);
    issue(1, 0, 2, "R6");          // A+48, one short
    issue(1, 0, 0, "R6");          // A+49 exactly T_CC after A+33 (R9)
    issue(1, 6, 3, "R8");          // no row on bank 6
    issue(0, 6, 0, "R4");          // quadrant 2 long idle
    issue(1, 6, 0, "R7");
    issue(1, 6, 2, "R6");
    idle(300);
    issue(0, 0, 0, "R5");          // long idle: timers expired
    issue(1, 0, 0, "R6");
    idle(1);
    issue(0, 12, 1, "R3");         // quadrant 0 busy again
    idle(3);

    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: pending results actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule